// File: doc/BRIEF.md
# Clock Mode Control Register

This block is one byte-wide control register on a small microcontroller's peripheral bus. It chooses where the system clock comes from and how fast it runs. It turns the oscillators on and off, reports which external oscillator type is fitted, and picks the stack page. Software writes the register at a fixed bus address and can read it back at the same address.

The system clock is produced as a clock-enable pulse on a fast reference clock. The two oscillators appear as tick inputs on that reference clock. The external source can run undivided, divided by 2 or divided by 8. The on-chip source passes its ticks straight through. After reset the block runs from the on-chip oscillator.

The processor-mode field and the oscillator-type bit accept only the first bus write after reset. When the requested external source cannot be used, the block stays on the on-chip source and raises a fallback flag. A change of source or ratio is applied only at a pulse boundary, so no system clock period is ever cut short.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the register reads 0x80, both write locks are clear, and the active source is the on-chip oscillator (src_onchip = 1).
- R2: A write with bus_addr = 0x3B updates the register, and writes to any other address change nothing. bus_rdata shows the register while bus_addr = 0x3B and shows zero for any other address.
- R3: Bits 1:0 (processor mode, 00 = single-chip) and bit 5 (oscillator type) accept only the first write to 0x3B after reset. That first write sets the lock even when it writes the reset value, and only a reset clears the lock. The other bits stay writable.
- R4: The control outputs follow the register bits as follows:
  - stack_page follows bit 2 (1 = page 1).
  - onchip_osc_en is the inverse of bit 3.
  - ext_osc_en is the inverse of bit 4.
  - ext_is_rc follows bit 5 (1 = RC, 0 = ceramic).
  - proc_mode follows bits 1:0.
- R5: Bits 7:6 select the system clock. 00 gives one pulse per 2 external ticks, 01 one per 8 external ticks, 10 one per on-chip tick, and 11 one per external tick.
- R6: When bit 5 = 1 (RC) and bits 7:6 = 11, the undivided ratio does not take effect. The on-chip source is used instead and fallback = 1.
- R7: When bits 7:6 select an external ratio and either bit 4 = 1 or xosc_ready = 0, the on-chip source is used and fallback = 1. When bits 7:6 = 10, or when the external source is usable, fallback = 0.
- R8: A change of the requested source or ratio takes effect only at a sys_clk_en pulse. The period that is running when the change is written completes at its old length.
- R9: If the active external source becomes unusable, the block moves to the on-chip source on the next clock edge and gives no further external pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Readback data, zero unless the address matches |
| xosc_ready | input | 1 | External oscillator is stable |
| xin_tick | input | 1 | External oscillator tick on the reference clock |
| osc_tick | input | 1 | On-chip oscillator tick on the reference clock |
| sys_clk_en | output | 1 | System clock enable pulse |
| src_onchip | output | 1 | Active source is the on-chip oscillator |
| fallback | output | 1 | Requested external source refused, on-chip held |
| stack_page | output | 1 | Stack page select |
| onchip_osc_en | output | 1 | On-chip oscillator enable |
| ext_osc_en | output | 1 | External oscillator enable |
| ext_is_rc | output | 1 | External oscillator type is RC |
| proc_mode | output | 2 | Processor mode field |

## Verification
The bench sweeps every ratio code against both oscillator types, the external stop bit and the ready input. For each combination it counts pulses over a 48-cycle window and compares the count with the period the requirements give. A design that ignored the RC restriction would show 48 pulses where 16 are expected. A design that ignored the stop bit or the ready input would keep counting external ticks and leave fallback low.

The locks are tested with a first write that repeats the reset value, followed by a conflicting write. A design that latched the lock only on a changed value would accept the second write.

A ratio change from 8 to 2 is written partway through a period. A design that switched immediately would give a short interval instead of exactly 8 cycles followed by 2.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int MAX_DIV   = 8;
    localparam int CNT_W     = $clog2(MAX_DIV);
    localparam logic [ADDR_W-1:0] REG_ADDR  = 8'h3B;
    localparam logic [DATA_W-1:0] RESET_VAL = 8'h80;

    typedef struct packed {
        logic [1:0] divsel;
        logic       rc;
        logic       xstop;
        logic       ostop;
        logic       stkpg;
        logic [1:0] pmode;
    } cfg_t;

    typedef enum logic [1:0] {
        SEL_ONCHIP = 2'd0,
        SEL_DIV1   = 2'd1,
        SEL_DIV2   = 2'd2,
        SEL_DIV8   = 2'd3
    } sel_t;

    function automatic logic [CNT_W-1:0] ratio_last(input sel_t s);
        case (s)
            SEL_DIV2: ratio_last = CNT_W'(1);
            SEL_DIV8: ratio_last = CNT_W'(MAX_DIV - 1);
            default:  ratio_last = '0;
        endcase
    endfunction

    function automatic sel_t decode_div(input logic [1:0] code);
        case (code)
            2'b00:   decode_div = SEL_DIV2;
            2'b01:   decode_div = SEL_DIV8;
            2'b11:   decode_div = SEL_DIV1;
            default: decode_div = SEL_ONCHIP;
        endcase
    endfunction

endpackage

// File: rtl/clkmode_regfile.sv
module clkmode_regfile
    import clkmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg,
    output logic              locked
);

    cfg_t wr;
    logic hit;

    assign wr  = cfg_t'(wdata);
    assign hit = we && (addr == REG_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= cfg_t'(RESET_VAL);
            locked <= 1'b0;
        end else if (hit) begin
            cfg.divsel <= wr.divsel;
            cfg.xstop  <= wr.xstop;
            cfg.ostop  <= wr.ostop;
            cfg.stkpg  <= wr.stkpg;
            if (!locked) begin
                cfg.rc    <= wr.rc;
                cfg.pmode <= wr.pmode;
            end
            locked <= 1'b1;
        end
    end

endmodule

// File: rtl/clkmode_srcsel.sv
module clkmode_srcsel
    import clkmode_pkg::*;
(
    input  cfg_t cfg,
    input  logic xosc_ready,
    output sel_t req,
    output logic fallback,
    output logic ext_avail
);

    sel_t want;
    logic blocked;

    assign ext_avail = !cfg.xstop && xosc_ready;
    assign want      = decode_div(cfg.divsel);
    assign blocked   = (want == SEL_DIV1) && cfg.rc;

    always_comb begin
        req      = want;
        fallback = 1'b0;
        if (want != SEL_ONCHIP && (!ext_avail || blocked)) begin
            req      = SEL_ONCHIP;
            fallback = 1'b1;
        end
    end

endmodule

// File: rtl/clkmode_divider.sv
module clkmode_divider
    import clkmode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sel_t req,
    input  logic ext_avail,
    input  logic xin_tick,
    input  logic osc_tick,
    output logic pulse,
    output sel_t act
);

    logic [CNT_W-1:0] cnt;
    logic             ext_act;
    logic             lost;

    assign ext_act = (act != SEL_ONCHIP);
    assign lost    = ext_act && !ext_avail;

    always_comb begin
        if (!ext_act) pulse = osc_tick;
        else          pulse = ext_avail && xin_tick && (cnt == ratio_last(act));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= SEL_ONCHIP;
            cnt <= '0;
        end else if (pulse || lost) begin
            act <= req;
            cnt <= '0;
        end else if (ext_act && xin_tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_we,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       xosc_ready,
    input  logic       xin_tick,
    input  logic       osc_tick,
    output logic       sys_clk_en,
    output logic       src_onchip,
    output logic       fallback,
    output logic       stack_page,
    output logic       onchip_osc_en,
    output logic       ext_osc_en,
    output logic       ext_is_rc,
    output logic [1:0] proc_mode
);

    cfg_t cfg;
    logic locked;
    sel_t req;
    sel_t act;
    logic ext_avail;

    clkmode_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .cfg    (cfg),
        .locked (locked)
    );

    clkmode_srcsel u_sel (
        .cfg        (cfg),
        .xosc_ready (xosc_ready),
        .req        (req),
        .fallback   (fallback),
        .ext_avail  (ext_avail)
    );

    clkmode_divider u_div (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .ext_avail (ext_avail),
        .xin_tick  (xin_tick),
        .osc_tick  (osc_tick),
        .pulse     (sys_clk_en),
        .act       (act)
    );

    assign bus_rdata     = (bus_addr == REG_ADDR) ? DATA_W'(cfg) : '0;
    assign src_onchip    = (act == SEL_ONCHIP);
    assign stack_page    = cfg.stkpg;
    assign onchip_osc_en = !cfg.ostop;
    assign ext_osc_en    = !cfg.xstop;
    assign ext_is_rc     = cfg.rc;
    assign proc_mode     = cfg.pmode;

endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk
    import clkmode_pkg::*;
(
    input logic clk,
    input logic rst,
    input cfg_t cfg,
    input logic locked,
    input sel_t act,
    input logic clk_en,
    input logic osc_tick,
    input logic ext_avail
);

    p_reset_val_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg == cfg_t'(RESET_VAL) && !locked && act == SEL_ONCHIP));

    p_lock_hold_r3: assert property (@(posedge clk) disable iff (rst)
        locked |=> ($stable(cfg.rc) && $stable(cfg.pmode)));

    p_no_direct_rc_r6: assert property (@(posedge clk) disable iff (rst)
        cfg.rc |-> (act != SEL_DIV1));

    p_onchip_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (clk_en && act == SEL_ONCHIP) |-> osc_tick);

    p_ext_pulse_ok_r7: assert property (@(posedge clk) disable iff (rst)
        (clk_en && act != SEL_ONCHIP) |-> ext_avail);

    p_lost_switch_r9: assert property (@(posedge clk) disable iff (rst)
        (!ext_avail) |=> (act == SEL_ONCHIP));

endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .locked    (locked),
    .act       (act),
    .clk_en    (sys_clk_en),
    .osc_tick  (osc_tick),
    .ext_avail (ext_avail)
);

// File: tb/clkmode_ctrl_tb.sv
module clkmode_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h3B;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       xosc_ready = 1'b0;
    logic       xin_tick = 1'b1;
    logic       osc_tick = 1'b0;
    logic       sys_clk_en, src_onchip, fallback, stack_page;
    logic       onchip_osc_en, ext_osc_en, ext_is_rc;
    logic [1:0] proc_mode;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int pcount = 0;
    int last_pulse = 0;
    logic [1:0] tdiv = 2'd0;

    always #5 clk = ~clk;

    clkmode_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xosc_ready(xosc_ready),
        .xin_tick(xin_tick), .osc_tick(osc_tick), .sys_clk_en(sys_clk_en),
        .src_onchip(src_onchip), .fallback(fallback), .stack_page(stack_page),
        .onchip_osc_en(onchip_osc_en), .ext_osc_en(ext_osc_en),
        .ext_is_rc(ext_is_rc), .proc_mode(proc_mode)
    );

    // on-chip oscillator: one tick every 3 reference cycles
    always @(posedge clk) begin
        tdiv     <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
        osc_tick <= (tdiv == 2'd2);
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sys_clk_en) begin
            pcount     <= pcount + 1;
            last_pulse <= cyc;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h3B;
    endtask

    task automatic count_pulses(output int n);
        int p0;
        @(negedge clk);
        #1 p0 = pcount;
        repeat (48) @(negedge clk);
        #1 n = pcount - p0;
    endtask

    initial begin
        int n, t0, t1;
        do_reset();
        #1;
        check("R1 reset readback", bus_rdata, 8'h80);
        check("R1 reset source", src_onchip, 1);

        // R2: foreign address
        wr(8'h3A, 8'h1F);
        bus_addr = 8'h3A; #1;
        check("R2 foreign readback", bus_rdata, 0);
        bus_addr = 8'h3B; #1;
        check("R2 foreign write ignored", bus_rdata, 8'h80);

        // R3: first write equal to reset value locks
        wr(8'h3B, 8'h80);
        wr(8'h3B, 8'hA3);
        #1 check("R3 lock after same-value write", bus_rdata, 8'h80);
        do_reset();
        wr(8'h3B, 8'h81);
        wr(8'h3B, 8'h86);
        #1 check("R3 lock keeps mode, others writable", bus_rdata, 8'h85);
        check("R3 proc_mode", proc_mode, 1);
        do_reset();
        #1 check("R3 reset unlocks readback", bus_rdata, 8'h80);
        wr(8'h3B, 8'hA0);
        #1 check("R3 write after reset", ext_is_rc, 1);

        // R4: outputs
        do_reset();
        wr(8'h3B, 8'h9C);
        #1;
        check("R4 stack_page", stack_page, 1);
        check("R4 onchip_osc_en", onchip_osc_en, 0);
        check("R4 ext_osc_en", ext_osc_en, 0);
        check("R4 ext_is_rc", ext_is_rc, 0);

        // R5/R6/R7 sweep
        for (int rc = 0; rc < 2; rc++)
            for (int xs = 0; xs < 2; xs++)
                for (int rdy = 0; rdy < 2; rdy++)
                    for (int dv = 0; dv < 4; dv++) begin
                        logic [7:0] v;
                        logic avail, onc;
                        int exp_n;
                        do_reset();
                        xosc_ready = rdy[0];
                        v = {dv[1:0], rc[0], xs[0], 4'b0000};
                        wr(8'h3B, v);
                        repeat (20) @(negedge clk);
                        avail = !xs[0] && rdy[0];
                        onc   = (dv == 2) || !avail || (rc == 1 && dv == 3);
                        if (onc)         exp_n = 16;
                        else if (dv == 0) exp_n = 24;
                        else if (dv == 1) exp_n = 6;
                        else              exp_n = 48;
                        #1;
                        check("R2 sweep readback", bus_rdata, v);
                        check("R4 sweep ext_is_rc", ext_is_rc, rc);
                        check("R7 sweep src_onchip", src_onchip, onc);
                        check("R6 R7 sweep fallback", fallback, (dv != 2) && onc);
                        count_pulses(n);
                        check("R5 sweep pulse count", n, exp_n);
                    end

        // R8: 8 -> 2 change mid-period
        do_reset();
        xosc_ready = 1'b1;
        wr(8'h3B, 8'h40);
        repeat (20) @(negedge clk);
        @(posedge sys_clk_en);
        @(negedge clk);
        #1 t0 = last_pulse;
        repeat (3) @(negedge clk);
        bus_we = 1'b1; bus_wdata = 8'h00;
        @(negedge clk);
        bus_we = 1'b0;
        @(posedge sys_clk_en); @(negedge clk);
        #1 t1 = last_pulse;
        check("R8 old period completes", t1 - t0, 8);
        @(posedge sys_clk_en); @(negedge clk);
        #1 check("R8 new period", last_pulse - t1, 2);

        // R9: external source lost
        @(negedge clk);
        xosc_ready = 1'b0;
        @(negedge clk);
        #1 check("R9 switch to on-chip", src_onchip, 1);
        check("R9 fallback flag", fallback, 1);
        count_pulses(n);
        check("R9 on-chip rate", n, 16);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule